// File: doc/BRIEF.md
# Rotational Frequency Detector

This block infers the sign of a frequency error in a clock and data recovery loop by watching how data transitions drift across the oversampled phase regions of the bit period. On every clock it receives three flags from the phase detector. A large-up flag marks a transition in the early region (region I). A large-down flag marks one in the late region (region IV). A small-up flag marks a transition close to the locked position.

The block keeps the most recent large-error region in a two-bit history. When a late-region hit follows a stored early-region hit, it issues one frequency-up pulse. When an early-region hit follows a stored late-region hit, it issues one frequency-down pulse. A pulse consumes the history. While the small-up flag is active the loop counts as locked. The history is then cleared and both outputs stay silent. A lock flop also keeps the detector disarmed for one further cycle after the flag drops. The outputs are registered, so each pulse appears one clock after the flag that completes the rotation and lasts one cycle.

Top module: `rot_freq_det`

## Requirements
- R1: While `rst_ni` is low, both outputs are 0 and the history is empty, so a first large-error flag after reset produces no pulse.
- R2: A `large_dn_i` cycle after a stored `large_up_i` hit drives `freq_up_o` high for exactly the one clock that follows that cycle.
- R3: A `large_up_i` cycle after a stored `large_dn_i` hit drives `freq_dn_o` high for exactly the one clock that follows that cycle.
- R4: Repeated hits in the region already stored produce no pulse, and the stored region is unchanged.
- R5: A pulse empties the history, so a lone opposite flag right after a pulse produces no pulse.
- R6: `large_up_i` and `large_dn_i` high in the same cycle produce no pulse and empty the history.
- R7: In every cycle where `small_up_i` is high, the history is emptied. Both outputs are 0 in the clock after each such cycle.
- R8: In the first cycle after `small_up_i` falls, the large-error flags are ignored, and the history stays empty.
- R9: `freq_up_o` and `freq_dn_o` are never both high.
- R10: Cycles with no flag set keep the stored region, so a rotation still completes across idle gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| small_up_i | input | 1 | Phase detector small-error up flag (lock indication) |
| large_up_i | input | 1 | Phase detector large-error up flag (region I hit) |
| large_dn_i | input | 1 | Phase detector large-error down flag (region IV hit) |
| freq_up_o | output | 1 | Frequency-up pulse, one cycle |
| freq_dn_o | output | 1 | Frequency-down pulse, one cycle |

## Verification
The assertions assume that all three flags are synchronous to `clk_i` and settle before each rising edge. They assume nothing about the flags being exclusive, so they also hold on cycles where both large-error flags are high together. The bench drives every input on the falling edge, which keeps it inside those assumptions. It deliberately mixes in simultaneous large flags, small-up bursts of one and several cycles, and an LFSR-driven stretch, so the conflict and re-arm paths are exercised as well as clean rotations.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  typedef enum logic [1:0] {
    HIST_NONE = 2'b00,
    HIST_EARLY = 2'b01,
    HIST_LATE = 2'b10
  } hist_e;
endpackage

// File: rtl/rfd_lock_gate.sv
module rfd_lock_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic small_up_i,
  output logic active_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= small_up_i;
  end

  // detector armed only when not locked now and not locked last cycle
  assign active_o = ~small_up_i & ~lock_q;

  p_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    small_up_i |=> !active_o);
endmodule

// File: rtl/rfd_region_hist.sv
module rfd_region_hist
  import rfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic clear_i,
  input  logic early_i,
  input  logic late_i,
  output logic rot_up_o,
  output logic rot_dn_o
);
  hist_e hist_q, hist_d;

  always_comb begin
    hist_d   = hist_q;
    rot_up_o = 1'b0;
    rot_dn_o = 1'b0;
    if (clear_i) begin
      hist_d = HIST_NONE;
    end else if (active_i) begin
      if (early_i && late_i) begin
        hist_d = HIST_NONE;
      end else if (late_i && hist_q == HIST_EARLY) begin
        rot_up_o = 1'b1;
        hist_d   = HIST_NONE;
      end else if (early_i && hist_q == HIST_LATE) begin
        rot_dn_o = 1'b1;
        hist_d   = HIST_NONE;
      end else if (early_i) begin
        hist_d = HIST_EARLY;
      end else if (late_i) begin
        hist_d = HIST_LATE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= HIST_NONE;
    else         hist_q <= hist_d;
  end

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> hist_q == HIST_NONE);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!early_i && !late_i && !clear_i) |=> $stable(hist_q));
  p_conflict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_i && late_i) |=> hist_q == HIST_NONE);
endmodule

// File: rtl/rfd_pulse_out.sv
module rfd_pulse_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rot_up_i,
  input  logic rot_dn_i,
  output logic freq_up_o,
  output logic freq_dn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_up_o <= 1'b0;
      freq_dn_o <= 1'b0;
    end else begin
      freq_up_o <= rot_up_i;
      freq_dn_o <= rot_dn_i;
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(freq_up_o && freq_dn_o));
endmodule

// File: rtl/rot_freq_det.sv
module rot_freq_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic small_up_i,
  input  logic large_up_i,
  input  logic large_dn_i,
  output logic freq_up_o,
  output logic freq_dn_o
);
  logic active, rot_up, rot_dn;

  rfd_lock_gate u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .small_up_i(small_up_i),
    .active_o  (active)
  );

  rfd_region_hist u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .clear_i (small_up_i),
    .early_i (large_up_i),
    .late_i  (large_dn_i),
    .rot_up_o(rot_up),
    .rot_dn_o(rot_dn)
  );

  rfd_pulse_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rot_up_i (rot_up),
    .rot_dn_i (rot_dn),
    .freq_up_o(freq_up_o),
    .freq_dn_o(freq_dn_o)
  );

  p_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    small_up_i |=> (!freq_up_o && !freq_dn_o));
  p_up_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_up_o |-> ($past(large_dn_i) && !$past(large_up_i)));
  p_dn_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_dn_o |-> ($past(large_up_i) && !$past(large_dn_i)));
  p_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_up_o || freq_dn_o) |=> (!freq_up_o && !freq_dn_o));
endmodule

// File: tb/rot_freq_det_bench.sv
`timescale 1ns/1ps
module rot_freq_det_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic su = 1'b0, lu = 1'b0, ld = 1'b0;
  logic fu, fd;
  int n_chk = 0, n_bad = 0;
  int last_reg = 0;   // 0 none, 1 early, 4 late
  bit lock_prev = 1'b0;
  bit exp_u = 1'b0, exp_d = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rot_freq_det u_rot_freq_det (
    .clk_i(clk), .rst_ni(rst_n), .small_up_i(su),
    .large_up_i(lu), .large_dn_i(ld), .freq_up_o(fu), .freq_dn_o(fd)
  );

  task automatic check(input string tag);
    n_chk++;
    if (fu !== exp_u || fd !== exp_d) begin
      n_bad++;
      $display("FAIL %s: up/dn actual %b%b expected %b%b", tag, fu, fd, exp_u, exp_d);
    end
  endtask

  task automatic step(input bit s, input bit u, input bit d, input string tag);
    @(negedge clk);
    su = s; lu = u; ld = d;
    @(posedge clk);
    exp_u = 0; exp_d = 0;
    if (s) last_reg = 0;
    else if (!lock_prev) begin
      if (u && d) last_reg = 0;
      else if (d && last_reg == 1) begin exp_u = 1; last_reg = 0; end
      else if (u && last_reg == 4) begin exp_d = 1; last_reg = 0; end
      else if (u) last_reg = 1;
      else if (d) last_reg = 4;
    end
    lock_prev = s;
    #1 check(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    exp_u = 0; exp_d = 0;
    check("R1 in reset");
    rst_n = 1'b1;
    step(0,0,1,"R1 first flag no pulse");
    step(0,0,0,"R1");
    // R3: late then early
    step(0,1,0,"R3 dn pulse");
    step(0,0,0,"R3 pulse ends");
    // R2: early then late
    step(0,1,0,"R2 store early");
    step(0,0,1,"R2 up pulse");
    step(0,0,0,"R2 pulse one cycle");
    // R5: lone opposite after pulse
    step(0,1,0,"R5 after clear");
    step(0,0,1,"R5 up");
    step(0,1,0,"R5 no pulse");
    step(0,0,0,"R5");
    // R4 repeats
    step(0,1,0,"R4 repeat early");
    step(0,1,0,"R4 repeat early");
    step(0,0,1,"R4 up after repeats");
    step(0,0,1,"R4 store late");
    step(0,0,1,"R4 repeat late");
    step(0,1,0,"R4 dn after repeats");
    step(0,0,0,"R4");
    // R10 idle gaps
    step(0,0,1,"R10 store late");
    repeat (5) step(0,0,0,"R10 idle");
    step(0,1,0,"R10 dn across gap");
    step(0,0,0,"R10");
    // R6 conflict
    step(0,1,0,"R6 store early");
    step(0,1,1,"R6 both flags");
    step(0,0,1,"R6 history cleared");
    step(0,0,0,"R6");
    // R7/R8 lock
    step(0,1,0,"R7 store early");
    step(1,0,1,"R7 locked silent");
    step(0,0,1,"R8 rearm ignore");
    step(0,0,0,"R8");
    step(0,0,1,"R7 history emptied");
    step(1,1,0,"R7 lock long");
    step(1,0,1,"R7 lock long");
    step(1,1,1,"R7 lock long");
    step(0,1,0,"R8 rearm ignore early");
    step(0,0,1,"R8 late stored");
    step(0,1,0,"R3 dn after rearm");
    // random stretch, R9 exclusivity included in compare
    lfsr = 32'h1ace;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[7:4] == 0, lfsr[0] & lfsr[2], lfsr[1] & lfsr[3], "R9 random");
      if (fu && fd) begin n_chk++; n_bad++; $display("FAIL R9: actual 11 expected not both"); end
    end
    rst_n = 1'b0;
    #1 exp_u = 0; exp_d = 0; check("R1 reset again");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule